// File: doc/BRIEF.md
# Processor Special Cycle Responder

This block sits on the host side of a bridge between a processor system bus and PCI. It takes a simplified transaction request from the bus interface: a valid strobe, a flag that marks a branch trace transaction, the cycle-type byte that the processor places in bits 15:8 of the second address phase, and the SMM-memory qualifier. It then performs the action that the cycle type calls for.

Most cycle types need nothing beyond being retired. A shutdown cycle drives an active-low INIT pulse back to the processor. A halt or a stop-clock acknowledge is forwarded to the PCI side and is retired only when the PCI side reports a master-abort termination. An SMI acknowledge sets or clears a persistent active-low SMI-active flag, depending on the SMM-memory qualifier. Branch trace transactions and reserved cycle types are retired at once and have no other effect. Only one transaction is in flight at a time. The `busy` output tells the bus side when a new request will be taken.

Top module: `special_cycle_responder`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `retire`=0, `busy`=0, `init_n`=1, `pci_fwd_valid`=0 and `smiact_n`=1.
- R2: A special cycle (`req_is_trace`=0) of type 0x00 (NOP), 0x02 (flush), 0x04 (sync) or 0x05 (flush acknowledge) is retired: `retire` is high in the cycle after the accepting edge. No other output changes except `busy`.
- R3: Every type value from 0x08 to 0xFF is reserved. It is retired in the same way as R2 and has no side effect.
- R4: A request with `req_is_trace`=1 is retired as in R2 whatever the type byte holds. It never starts INIT, never forwards to PCI and never changes `smiact_n`.
- R5: A shutdown (type 0x01) is retired, and `init_n` goes low in that same cycle. `init_n` stays low for exactly INIT_LEN cycles (default 4, never less than 4). Nothing is forwarded to PCI.
- R6: A shutdown accepted while `init_n` is still low restarts the count, so `init_n` stays low for INIT_LEN cycles counted from the second retire.
- R7: A halt (type 0x03) raises `pci_fwd_valid` with `pci_fwd_kind`=0 in the cycle after acceptance. Both hold until an edge where `pci_mabort` is high. After that edge `pci_fwd_valid` is 0 and `retire` is 1.
- R8: A stop-clock acknowledge (type 0x06) behaves as in R7 but with `pci_fwd_kind`=1.
- R9: An SMI acknowledge (type 0x07) is retired at once. From its retire cycle on, `smiact_n` equals the inverse of the `req_smm` value it carried. `smiact_n` holds that value until the next accepted SMI acknowledge.
- R10: A request is accepted at an edge where `req_valid`=1 and `busy`=0. `busy` is high from the cycle after acceptance through the retire cycle and low after it. A request presented while `busy` is high has no effect.
- R11: `pci_mabort` has no effect unless a forwarded cycle is waiting.
- R12: `retire` is a single-cycle pulse. Each accepted request produces exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_is_trace | input | 1 | 1 = branch trace transaction, 0 = special cycle |
| req_type | input | 8 | Cycle type (second-phase address bits 15:8) |
| req_smm | input | 1 | SMM-memory qualifier, active high |
| pci_mabort | input | 1 | PCI side reports master-abort termination |
| busy | output | 1 | A transaction is in progress |
| retire | output | 1 | One-cycle host-side retire strobe |
| init_n | output | 1 | Active-low INIT to the processor |
| pci_fwd_valid | output | 1 | Request to run a special cycle on PCI |
| pci_fwd_kind | output | 1 | 0 = halt, 1 = stop grant |
| smiact_n | output | 1 | Active-low SMI-active flag |

## Verification
A controller stuck in its waiting state shows up as `busy` and `pci_fwd_valid` still high in the first cycle after the master-abort edge. A lost return to idle shows up as a missing `retire` one cycle after an immediate-retire request. A wrong INIT count shows up on the edge where `init_n` should rise, which comes four cycles after the shutdown retire. A stale SMI flag is visible on `smiact_n` in the retire cycle of the next SMI acknowledge. The reference model compares all outputs on every cycle, so each of these faults is reported within one clock of the cycle where it should have been visible.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [7:0] {
    CT_NOP      = 8'h00,
    CT_SHUTDOWN = 8'h01,
    CT_FLUSH    = 8'h02,
    CT_HALT     = 8'h03,
    CT_SYNC     = 8'h04,
    CT_FLUSHACK = 8'h05,
    CT_STOPACK  = 8'h06,
    CT_SMIACK   = 8'h07
  } cycle_type_e;

  typedef enum logic [2:0] {
    ACT_RETIRE,
    ACT_SHUTDOWN,
    ACT_FWD_HALT,
    ACT_FWD_STOP,
    ACT_SMI
  } action_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE
  } state_e;

  // Branch trace and reserved codes fall through to a plain retire.
  function automatic action_e decode_action(input logic is_trace, input logic [7:0] code);
    action_e a;
    a = ACT_RETIRE;
    if (!is_trace) begin
      case (code)
        CT_SHUTDOWN: a = ACT_SHUTDOWN;
        CT_HALT:     a = ACT_FWD_HALT;
        CT_STOPACK:  a = ACT_FWD_STOP;
        CT_SMIACK:   a = ACT_SMI;
        default:     a = ACT_RETIRE;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/scr_init_timer.sv
module scr_init_timer #(
  parameter int INIT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic init_n
);
  localparam int CNT_W = $clog2(INIT_LEN + 1);
  localparam int RUN_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             init_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      init_n_q <= 1'b1;
    end else if (start) begin
      cnt_q    <= CNT_W'(INIT_LEN - 1);
      init_n_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q    <= cnt_q - 1'b1;
    end else begin
      init_n_q <= 1'b1;
    end
  end

  assign init_n = init_n_q;

  // Length of the current low run, saturating; used only by the check below.
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst) low_run_q <= '0;
    else if (init_n_q) low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  a_r5_min_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(init_n_q) |-> (low_run_q >= RUN_W'(INIT_LEN)));

  a_r6_start_drives_low: assert property (@(posedge clk) disable iff (rst)
    start |=> !init_n_q);

endmodule

// File: rtl/scr_smi_flag.sv
module scr_smi_flag (
  input  logic clk,
  input  logic rst,
  input  logic update,
  input  logic smm,
  output logic smiact_n
);
  logic flag_n_q;

  always_ff @(posedge clk) begin
    if (rst)         flag_n_q <= 1'b1;
    else if (update) flag_n_q <= ~smm;
  end

  assign smiact_n = flag_n_q;

  a_r9_flag_holds: assert property (@(posedge clk) disable iff (rst)
    !update |=> $stable(flag_n_q));

  a_r9_flag_follows: assert property (@(posedge clk) disable iff (rst)
    update |=> (flag_n_q == !$past(smm)));

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  action_e act,
  input  logic    pci_mabort,
  output logic    accept,
  output logic    retire,
  output logic    busy,
  output logic    fwd_valid,
  output logic    fwd_kind
);
  state_e state_q;
  logic   retire_q, busy_q, fwd_valid_q, fwd_kind_q;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      retire_q    <= 1'b0;
      busy_q      <= 1'b0;
      fwd_valid_q <= 1'b0;
      fwd_kind_q  <= 1'b0;
    end else begin
      retire_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            busy_q <= 1'b1;
            if (act == ACT_FWD_HALT || act == ACT_FWD_STOP) begin
              state_q     <= ST_WAIT;
              fwd_valid_q <= 1'b1;
              fwd_kind_q  <= (act == ACT_FWD_STOP);
            end else begin
              state_q  <= ST_DONE;
              retire_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (pci_mabort) begin
            state_q     <= ST_DONE;
            fwd_valid_q <= 1'b0;
            retire_q    <= 1'b1;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end

  assign retire    = retire_q;
  assign busy      = busy_q;
  assign fwd_valid = fwd_valid_q;
  assign fwd_kind  = fwd_kind_q;

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy_q && !retire_q && !fwd_valid_q));

  a_r10_retire_in_busy: assert property (@(posedge clk) disable iff (rst)
    retire_q |-> busy_q);

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !accept);

  a_r12_retire_pulse: assert property (@(posedge clk) disable iff (rst)
    retire_q |=> !retire_q);

  a_r7_fwd_hold: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid_q && !pci_mabort) |=> (fwd_valid_q && $stable(fwd_kind_q)));

  a_r7_fwd_release: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid_q && pci_mabort) |=> (!fwd_valid_q && retire_q));

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (!fwd_valid_q && !accept) |=> !fwd_valid_q);

endmodule

// File: rtl/special_cycle_responder.sv
module special_cycle_responder
  import scr_pkg::*;
#(
  parameter int INIT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_is_trace,
  input  logic [7:0] req_type,
  input  logic       req_smm,
  input  logic       pci_mabort,
  output logic       busy,
  output logic       retire,
  output logic       init_n,
  output logic       pci_fwd_valid,
  output logic       pci_fwd_kind,
  output logic       smiact_n
);
  localparam int PULSE_LEN = (INIT_LEN < 4) ? 4 : INIT_LEN;

  action_e act;
  logic    accept;

  assign act = decode_action(req_is_trace, req_type);

  scr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .act        (act),
    .pci_mabort (pci_mabort),
    .accept     (accept),
    .retire     (retire),
    .busy       (busy),
    .fwd_valid  (pci_fwd_valid),
    .fwd_kind   (pci_fwd_kind)
  );

  scr_init_timer #(.INIT_LEN(PULSE_LEN)) u_init (
    .clk    (clk),
    .rst    (rst),
    .start  (accept && (act == ACT_SHUTDOWN)),
    .init_n (init_n)
  );

  scr_smi_flag u_smi (
    .clk      (clk),
    .rst      (rst),
    .update   (accept && (act == ACT_SMI)),
    .smm      (req_smm),
    .smiact_n (smiact_n)
  );

  a_r4_trace_inert: assert property (@(posedge clk) disable iff (rst)
    (accept && req_is_trace) |=> ($stable(smiact_n) && !pci_fwd_valid && retire));

  a_r5_shutdown_retire: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_is_trace && req_type == 8'h01) |=> (retire && !init_n && !pci_fwd_valid));

endmodule

// File: tb/test_special_cycle_responder.sv
`timescale 1ns/1ps
module test_special_cycle_responder;
  localparam int INIT_LEN = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_is_trace = 1'b0;
  logic [7:0] req_type = 8'h00;
  logic       req_smm = 1'b0;
  logic       pci_mabort = 1'b0;
  logic       busy, retire, init_n, pci_fwd_valid, pci_fwd_kind, smiact_n;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  // reference model state
  int m_phase = 0;    // 0 idle, 1 waiting for abort, 2 retire cycle
  int m_busy = 0, m_retire = 0, m_init_left = 0, m_fwd = 0, m_kind = 0, m_smi_n = 1;

  always #2.5 clk = ~clk;

  special_cycle_responder #(.INIT_LEN(INIT_LEN)) i_special_cycle_responder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_trace(req_is_trace),
    .req_type(req_type), .req_smm(req_smm), .pci_mabort(pci_mabort),
    .busy(busy), .retire(retire), .init_n(init_n), .pci_fwd_valid(pci_fwd_valid),
    .pci_fwd_kind(pci_fwd_kind), .smiact_n(smiact_n)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_busy = 0; m_retire = 0; m_init_left = 0;
      m_fwd = 0; m_kind = 0; m_smi_n = 1;
    end else begin
      m_retire = 0;
      if (m_init_left > 0) m_init_left = m_init_left - 1;
      if (m_phase == 0) begin
        if (req_valid) begin
          m_busy = 1;
          if (!req_is_trace && (req_type == 8'h03 || req_type == 8'h06)) begin
            m_phase = 1; m_fwd = 1; m_kind = (req_type == 8'h06) ? 1 : 0;
          end else begin
            m_phase = 2; m_retire = 1;
            if (!req_is_trace && req_type == 8'h01) m_init_left = INIT_LEN;
            if (!req_is_trace && req_type == 8'h07) m_smi_n = req_smm ? 0 : 1;
          end
        end
      end else if (m_phase == 1) begin
        if (pci_mabort) begin
          m_phase = 2; m_fwd = 0; m_retire = 1;
        end
      end else begin
        m_phase = 0; m_busy = 0;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("retire (R12)", retire, m_retire);
      chk("busy (R10)", busy, m_busy);
      chk("init_n (R5)", init_n, (m_init_left == 0) ? 1 : 0);
      chk("pci_fwd_valid (R7)", pci_fwd_valid, m_fwd);
      if (m_fwd != 0) chk("pci_fwd_kind (R8)", pci_fwd_kind, m_kind);
      chk("smiact_n (R9)", smiact_n, m_smi_n);
    end
  end

  task automatic issue(bit trace, logic [7:0] code, bit smm);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_is_trace = trace; req_type = code; req_smm = smm;
    @(negedge clk);
    req_valid = 1'b0; req_is_trace = 1'b0; req_type = 8'h00; req_smm = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic abort_pulse();
    pci_mabort = 1'b1;
    @(negedge clk);
    pci_mabort = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (R10) actual hung expected done");
      summary();
    end
  end

  initial begin
    tag = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);
    chk("reset busy (R1)", busy, 0);
    chk("reset smiact_n (R1)", smiact_n, 1);

    tag = "R2";
    issue(0, 8'h00, 0); issue(0, 8'h02, 1); issue(0, 8'h04, 0); issue(0, 8'h05, 1);
    idle(3);

    tag = "R3";
    issue(0, 8'h08, 1); issue(0, 8'h80, 0); issue(0, 8'hFF, 1); issue(0, 8'h81, 1);
    idle(3);

    tag = "R4";
    issue(1, 8'h01, 0); issue(1, 8'h03, 0); issue(1, 8'h06, 1); issue(1, 8'h07, 1);
    idle(2);
    chk("trace left init_n high (R4)", init_n, 1);
    chk("trace left smiact_n (R4)", smiact_n, 1);

    tag = "R5";
    issue(0, 8'h01, 0);
    idle(8);

    tag = "R6";
    issue(0, 8'h01, 0);
    idle(1);
    issue(0, 8'h01, 0);
    idle(2);
    chk("restarted pulse still low (R6)", init_n, 0);
    idle(6);

    tag = "R7";
    issue(0, 8'h03, 0);
    idle(5);
    abort_pulse();
    idle(3);

    tag = "R10";
    issue(0, 8'h06, 0);
    req_valid = 1'b1; req_type = 8'h01;
    idle(2);
    req_valid = 1'b0; req_type = 8'h00;
    chk("request while busy ignored (R10)", init_n, 1);
    tag = "R8";
    idle(2);
    abort_pulse();
    idle(3);

    tag = "R9";
    issue(0, 8'h07, 0);
    issue(0, 8'h07, 1);
    issue(0, 8'h00, 0);
    issue(0, 8'h05, 0);
    idle(3);
    chk("flag persists (R9)", smiact_n, 0);
    issue(0, 8'h07, 0);
    idle(3);

    tag = "R11";
    abort_pulse();
    idle(2);
    issue(0, 8'h02, 0);
    abort_pulse();
    idle(2);
    chk("abort while idle (R11)", pci_fwd_valid, 0);

    tag = "R12";
    issue(0, 8'h03, 0);
    idle(1);
    pci_mabort = 1'b1;
    idle(3);
    pci_mabort = 1'b0;
    idle(3);

    summary();
  end

endmodule